// File: doc/BRIEF.md
# DRAM Bank Timing Gate

This block sits beside a DRAM command scheduler and tracks the protocol timing of one rank. It watches every command the scheduler issues: activate, precharge, read and write, each tagged with a bank number. From that history it drives four per-bank "allowed" vectors, one each for activate, precharge, read and write. The scheduler may only pick a command whose flag is high in the current cycle.

Each bank has its own countdown timers for the following gaps:

- activate to column access
- precharge to activate
- activate to precharge
- activate to activate
- write to precharge

Two limits span the whole rank:

- the write-to-read turnaround
- a rolling window that admits at most four activates

The block also records whether each bank holds an open row. All delays are parameters counted in clock cycles.

The command input is observed, not handshaken. The tracker never exerts back-pressure and has no ready signal, so every cycle with `cmd_valid` high counts as an issued command. If a command is issued while its flag is low, a sticky `violation` output is raised for checking.

A command sampled at clock edge t with a delay of D cycles makes the dependent flag high from cycle t+D onward. Here cycle t is the cycle in which the command was presented.

Top module: `dtt_timing_tracker`

## Requirements
- R1: After reset every bank is closed, `act_ok` is all ones, `pre_ok`, `rd_ok` and `wr_ok` are all zero, and `violation` is low.
- R2: Read and write to a bank are allowed only while that bank is open and at least T_RCD cycles after its activate.
- R3: An activate to a bank is allowed only at least T_RP cycles after that bank's precharge.
- R4: A precharge to a bank is allowed only at least T_RAS cycles after that bank's activate.
- R5: Two activates to the same bank are at least T_RAS+T_RP cycles apart.
- R6: A fifth activate anywhere in the rank is blocked until T_FAW cycles have passed since the oldest of the four most recent activates.
- R7: After a write to any bank, reads to every bank are blocked for T_WTR cycles.
- R8: A precharge to a bank is allowed only at least T_WR cycles after the last write to that bank.
- R9: An activate is allowed only to a closed bank. Precharge, read and write are allowed only to an open bank. Activate opens the bank and precharge closes it.
- R10: `violation` rises the cycle after a command is presented while its allowed flag is low, and then stays high until reset.
- R11: `cmd_op` encodes activate=0, precharge=1, read=2, write=3. A cycle with `cmd_valid` low changes no state.
- R12: Banks are tracked independently. A command to one bank does not change another bank's per-bank flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_op | input | 2 | Command code (0 act, 1 pre, 2 rd, 3 wr) |
| cmd_bank | input | BANK_W (3) | Target bank |
| act_ok | output | N_BANKS (8) | Activate allowed, per bank |
| pre_ok | output | N_BANKS (8) | Precharge allowed, per bank |
| rd_ok | output | N_BANKS (8) | Read allowed, per bank |
| wr_ok | output | N_BANKS (8) | Write allowed, per bank |
| violation | output | 1 | Sticky: a disallowed command was issued |

## Verification
One write starts two gates on the same clock edge. These are the rank-wide read turnaround and that bank's precharge recovery. The bench checks that `rd_ok` and `pre_ok` are released at their separate cycles. A separate collision arises when bank-local activate timing and the rank four-activate window both govern `act_ok` in one cycle. The bench provokes it with a burst of activates to fresh banks, which are free per bank but must stay blocked until the window's oldest entry ages out. A cross-bank case also applies: a write to one bank must block reads on a different open bank.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_PRE = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } dtt_cmd_e;
endpackage

// File: rtl/dtt_downcnt.sv
// Countdown gate: after a load, idle is low for DELAY-1 cycles.
module dtt_downcnt #(
  parameter int unsigned DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic idle
);
  localparam int unsigned W = (DELAY > 2) ? $clog2(DELAY) : 1;
  localparam logic [W-1:0] LOADV = W'(DELAY - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= LOADV;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign idle = (cnt == '0);

  // R2 R3 R4 R8: a gate only re-arms on a load, never by itself
  cnt_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> cnt <= $past(cnt));
endmodule

// File: rtl/dtt_bank_timer.sv
// Per-bank row state and timing gates.
module dtt_bank_timer #(
  parameter int unsigned TRCD = 4,
  parameter int unsigned TRP  = 4,
  parameter int unsigned TRAS = 10,
  parameter int unsigned TRC  = 14,
  parameter int unsigned TWR  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic do_act,
  input  logic do_pre,
  input  logic do_wr,
  output logic act_ok,
  output logic pre_ok,
  output logic col_ok
);
  logic row_open;
  logic rcd_idle, ras_idle, rc_idle, rp_idle, wr_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      row_open <= 1'b0;
    else if (do_act) row_open <= 1'b1;
    else if (do_pre) row_open <= 1'b0;
  end

  dtt_downcnt #(.DELAY(TRCD)) rcd_u (.clk(clk), .rst_n(rst_n), .load(do_act), .idle(rcd_idle));
  dtt_downcnt #(.DELAY(TRAS)) ras_u (.clk(clk), .rst_n(rst_n), .load(do_act), .idle(ras_idle));
  dtt_downcnt #(.DELAY(TRC))  rc_u  (.clk(clk), .rst_n(rst_n), .load(do_act), .idle(rc_idle));
  dtt_downcnt #(.DELAY(TRP))  rp_u  (.clk(clk), .rst_n(rst_n), .load(do_pre), .idle(rp_idle));
  dtt_downcnt #(.DELAY(TWR))  wr_u  (.clk(clk), .rst_n(rst_n), .load(do_wr),  .idle(wr_idle));

  assign act_ok = !row_open && rp_idle && rc_idle;
  assign pre_ok = row_open && ras_idle && wr_idle;
  assign col_ok = row_open && rcd_idle;

  // R2
  act_blocks_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_act && (TRCD > 1)) |=> !col_ok);
  // R4
  act_blocks_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_act && (TRAS > 1)) |=> !pre_ok);
  // R3
  pre_blocks_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pre && (TRP > 1)) |=> !act_ok);
  // R8
  wr_blocks_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && (TWR > 1)) |=> !pre_ok);
  // R9
  open_blocks_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_act |=> !act_ok);
endmodule

// File: rtl/dtt_act_window.sv
// Rank-wide rolling activate window: ages of the most recent SLOTS activates.
module dtt_act_window #(
  parameter int unsigned TFAW  = 16,
  parameter int unsigned SLOTS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_in,
  output logic faw_ok
);
  localparam int unsigned AW = $clog2(TFAW + 1);
  localparam logic [AW-1:0] AGE_MAX = AW'(TFAW);

  logic [AW-1:0]    age [SLOTS];
  logic [SLOTS-1:0] filled;

  function automatic logic [AW-1:0] older(input logic [AW-1:0] a);
    return (a >= AGE_MAX) ? AGE_MAX : a + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) age[i] <= '0;
      filled <= '0;
    end else if (act_in) begin
      age[0] <= AW'(1);
      for (int i = 1; i < SLOTS; i++) age[i] <= older(age[i-1]);
      filled <= {filled[SLOTS-2:0], 1'b1};
    end else begin
      for (int i = 0; i < SLOTS; i++) age[i] <= older(age[i]);
    end
  end

  assign faw_ok = !filled[SLOTS-1] || (age[SLOTS-1] >= AGE_MAX);

  // R6: the window can only close as the result of an activate
  faw_close_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(faw_ok) |-> $past(act_in));
endmodule

// File: rtl/dtt_timing_tracker.sv
module dtt_timing_tracker
  import dtt_pkg::*;
#(
  parameter int unsigned N_BANKS  = 8,
  parameter int unsigned T_RCD    = 4,
  parameter int unsigned T_RP     = 4,
  parameter int unsigned T_RAS    = 10,
  parameter int unsigned T_FAW    = 16,
  parameter int unsigned T_WTR    = 3,
  parameter int unsigned T_WR     = 5,
  parameter int unsigned ACT_SLOTS = 4,
  localparam int unsigned BANK_W  = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [BANK_W-1:0]  cmd_bank,
  output logic [N_BANKS-1:0] act_ok,
  output logic [N_BANKS-1:0] pre_ok,
  output logic [N_BANKS-1:0] rd_ok,
  output logic [N_BANKS-1:0] wr_ok,
  output logic               violation
);
  localparam int unsigned T_RC = T_RAS + T_RP;

  dtt_cmd_e op;
  logic any_act, any_pre, any_wr;
  logic faw_ok, wtr_ok;
  logic chosen_ok;
  logic [N_BANKS-1:0] b_act_ok, b_pre_ok, b_col_ok;

  assign op      = dtt_cmd_e'(cmd_op);
  assign any_act = cmd_valid && (op == CMD_ACT);
  assign any_pre = cmd_valid && (op == CMD_PRE);
  assign any_wr  = cmd_valid && (op == CMD_WR);

  for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
    logic sel;
    assign sel = (cmd_bank == BANK_W'(g));
    dtt_bank_timer #(
      .TRCD(T_RCD), .TRP(T_RP), .TRAS(T_RAS), .TRC(T_RC), .TWR(T_WR)
    ) bank_u (
      .clk(clk), .rst_n(rst_n),
      .do_act(any_act && sel), .do_pre(any_pre && sel), .do_wr(any_wr && sel),
      .act_ok(b_act_ok[g]), .pre_ok(b_pre_ok[g]), .col_ok(b_col_ok[g])
    );
    assign act_ok[g] = b_act_ok[g] && faw_ok;
    assign pre_ok[g] = b_pre_ok[g];
    assign rd_ok[g]  = b_col_ok[g] && wtr_ok;
    assign wr_ok[g]  = b_col_ok[g];
  end

  dtt_act_window #(.TFAW(T_FAW), .SLOTS(ACT_SLOTS)) faw_u (
    .clk(clk), .rst_n(rst_n), .act_in(any_act), .faw_ok(faw_ok)
  );

  dtt_downcnt #(.DELAY(T_WTR)) wtr_u (
    .clk(clk), .rst_n(rst_n), .load(any_wr), .idle(wtr_ok)
  );

  always_comb begin
    unique case (op)
      CMD_ACT: chosen_ok = act_ok[cmd_bank];
      CMD_PRE: chosen_ok = pre_ok[cmd_bank];
      CMD_RD:  chosen_ok = rd_ok[cmd_bank];
      default: chosen_ok = wr_ok[cmd_bank];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      violation <= 1'b0;
    else if (cmd_valid && !chosen_ok) violation <= 1'b1;
  end

  // R10
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation);
  // R11
  idle_no_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(violation));
  // R7
  wtr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && (T_WTR > 1)) |=> (rd_ok == '0));
endmodule

// File: tb/dtt_timing_tracker_tb_top.sv
module dtt_timing_tracker_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [2:0] cmd_bank = 3'd0;
  logic [7:0] act_ok, pre_ok, rd_ok, wr_ok;
  logic       violation;

  dtt_timing_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .act_ok(act_ok), .pre_ok(pre_ok), .rd_ok(rd_ok),
    .wr_ok(wr_ok), .violation(violation)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // check kinds: 0 none, 1 act_ok, 2 pre_ok, 3 rd_ok, 4 wr_ok, 5 violation
  typedef struct packed {
    logic [7:0] cyc;
    logic       v;
    logic [1:0] op;
    logic [2:0] bank;
    logic [2:0] ck;
    logic [2:0] cb;
    logic       ex;
    logic [3:0] req;
  } ev_t;

  localparam int NEV = 29;
  localparam ev_t EVS [NEV] = '{
    '{8'd0,  1'b1, 2'd0, 3'd0, 3'd1, 3'd0, 1'b1, 4'd1},  // R1 fresh bank may open
    '{8'd1,  1'b0, 2'd0, 3'd0, 3'd3, 3'd0, 1'b0, 4'd2},  // R2
    '{8'd2,  1'b0, 2'd0, 3'd0, 3'd2, 3'd0, 1'b0, 4'd4},  // R4
    '{8'd3,  1'b0, 2'd0, 3'd0, 3'd4, 3'd0, 1'b0, 4'd2},  // R2
    '{8'd4,  1'b1, 2'd2, 3'd0, 3'd3, 3'd0, 1'b1, 4'd2},  // R2 release
    '{8'd5,  1'b0, 2'd0, 3'd0, 3'd1, 3'd0, 1'b0, 4'd9},  // R9 open bank
    '{8'd6,  1'b1, 2'd3, 3'd0, 3'd4, 3'd0, 1'b1, 4'd2},  // R2
    '{8'd7,  1'b0, 2'd0, 3'd0, 3'd3, 3'd0, 1'b0, 4'd7},  // R7
    '{8'd8,  1'b0, 2'd0, 3'd0, 3'd3, 3'd0, 1'b0, 4'd7},  // R7
    '{8'd9,  1'b0, 2'd0, 3'd0, 3'd3, 3'd0, 1'b1, 4'd7},  // R7 release
    '{8'd10, 1'b0, 2'd0, 3'd0, 3'd2, 3'd0, 1'b0, 4'd8},  // R8
    '{8'd11, 1'b1, 2'd1, 3'd0, 3'd2, 3'd0, 1'b1, 4'd8},  // R8 release
    '{8'd12, 1'b0, 2'd0, 3'd0, 3'd1, 3'd0, 1'b0, 4'd3},  // R3
    '{8'd13, 1'b0, 2'd0, 3'd0, 3'd3, 3'd0, 1'b0, 4'd9},  // R9 closed
    '{8'd14, 1'b0, 2'd0, 3'd0, 3'd1, 3'd0, 1'b0, 4'd3},  // R3
    '{8'd15, 1'b1, 2'd0, 3'd0, 3'd1, 3'd0, 1'b1, 4'd3},  // R3 release
    '{8'd16, 1'b1, 2'd0, 3'd1, 3'd1, 3'd1, 1'b1, 4'd12}, // R12
    '{8'd20, 1'b0, 2'd0, 3'd0, 3'd3, 3'd1, 1'b1, 4'd12}, // R12
    '{8'd25, 1'b0, 2'd0, 3'd0, 3'd2, 3'd1, 1'b0, 4'd4},  // R4
    '{8'd26, 1'b1, 2'd1, 3'd1, 3'd2, 3'd1, 1'b1, 4'd4},  // R4 release
    '{8'd29, 1'b0, 2'd0, 3'd0, 3'd1, 3'd1, 1'b0, 4'd5},  // R5
    '{8'd30, 1'b1, 2'd0, 3'd1, 3'd1, 3'd1, 1'b1, 4'd5},  // R5 release
    '{8'd31, 1'b1, 2'd0, 3'd2, 3'd1, 3'd2, 1'b1, 4'd6},  // R6
    '{8'd32, 1'b1, 2'd0, 3'd3, 3'd1, 3'd3, 1'b1, 4'd6},  // R6
    '{8'd33, 1'b1, 2'd0, 3'd4, 3'd1, 3'd4, 1'b1, 4'd6},  // R6
    '{8'd35, 1'b0, 2'd0, 3'd5, 3'd1, 3'd5, 1'b0, 4'd6},  // R6 window full; R11 invalid act
    '{8'd36, 1'b0, 2'd0, 3'd0, 3'd3, 3'd5, 1'b0, 4'd11}, // R11 bank 5 still closed
    '{8'd45, 1'b0, 2'd0, 3'd0, 3'd1, 3'd5, 1'b0, 4'd6},  // R6
    '{8'd46, 1'b1, 2'd0, 3'd5, 3'd1, 3'd5, 1'b1, 4'd6}   // R6 release
  };

  task automatic check(input logic [31:0] got, input logic [31:0] exp,
                       input int req, input string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic flag(input logic [2:0] ck, input logic [2:0] cb);
    case (ck)
      3'd1:    return act_ok[cb];
      3'd2:    return pre_ok[cb];
      3'd3:    return rd_ok[cb];
      3'd4:    return wr_ok[cb];
      default: return violation;
    endcase
  endfunction

  task automatic drive(input logic v, input logic [1:0] op, input logic [2:0] bank);
    cmd_valid = v;
    cmd_op    = op;
    cmd_bank  = bank;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired before the bench finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p;
    p = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // table walk: cycle c = negedge index after reset release
    for (int c = 0; c < 48; c++) begin
      if (c > 0) @(negedge clk);
      if (p < NEV && int'(EVS[p].cyc) == c) begin
        if (EVS[p].ck != 3'd0)
          check({31'd0, flag(EVS[p].ck, EVS[p].cb)}, {31'd0, EVS[p].ex},
                int'(EVS[p].req), $sformatf("cycle %0d flag %0d bank %0d", c, EVS[p].ck, EVS[p].cb));
        drive(EVS[p].v, EVS[p].op, EVS[p].bank);
        p++;
      end else begin
        drive(1'b0, 2'd0, 3'd0);
      end
    end
    @(negedge clk);
    // R10: no violation so far in a legal sequence
    check({31'd0, violation}, 32'd0, 10, "legal sequence clean");
    // R10: read to closed bank 6 is illegal
    drive(1'b1, 2'd2, 3'd6);
    @(negedge clk);
    drive(1'b0, 2'd0, 3'd0);
    check({31'd0, violation}, 32'd1, 10, "violation raised");
    repeat (3) @(negedge clk);
    check({31'd0, violation}, 32'd1, 10, "violation sticky");

    // R1: reset state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check({24'd0, act_ok}, 32'hFF, 1, "act_ok after reset");
    check({24'd0, pre_ok}, 32'h00, 1, "pre_ok after reset");
    check({24'd0, rd_ok},  32'h00, 1, "rd_ok after reset");
    check({24'd0, wr_ok},  32'h00, 1, "wr_ok after reset");
    check({31'd0, violation}, 32'd0, 1, "violation after reset");

    // R7: write to bank 2 blocks reads to bank 3 (rank-wide turnaround)
    drive(1'b1, 2'd0, 3'd2);           // c0 act b2
    @(negedge clk); drive(1'b1, 2'd0, 3'd3); // c1 act b3
    @(negedge clk); drive(1'b0, 2'd0, 3'd0); // c2
    repeat (3) @(negedge clk);          // c5
    check({31'd0, rd_ok[3]}, 32'd1, 7, "bank3 read open before write");
    drive(1'b1, 2'd3, 3'd2);           // c5 write b2
    @(negedge clk); drive(1'b0, 2'd0, 3'd0); // c6
    check({31'd0, rd_ok[3]}, 32'd0, 7, "bank3 read blocked by bank2 write");
    check({31'd0, wr_ok[3]}, 32'd1, 7, "writes not blocked by turnaround");
    @(negedge clk);                     // c7
    check({31'd0, rd_ok[3]}, 32'd0, 7, "bank3 read still blocked");
    @(negedge clk);                     // c8
    check({31'd0, rd_ok[3]}, 32'd1, 7, "bank3 read released");
    check({31'd0, violation}, 32'd0, 10, "directed sequence clean");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule